// File: doc/BRIEF.md
# PHY Management Register File

This block is the management-data slave of an Ethernet PHY. It watches the serial management clock and data line, decodes read and write frames, and serves a small register space: a control register whose bits drive power-down, isolation and a self-clearing soft reset; a fixed status word; two identifier words; an advertisement word; and six saturating event counters that the datapath bumps through single-cycle strobes.

The management clock is sampled by the block's own system clock, so every action happens on a detected rising edge of that clock. A preamble of ones is accepted but not required: a frame begins at the first `0` followed by `1`. The strapped address is compared in two ways. In adapter mode only the two low address bits are strapped, so only addresses 0 to 3 can answer. In repeater mode all five bits take part. A frame for another address, or with an unknown opcode, is tracked to its end and leaves the line alone.

Top module: `phy_mgmt_regfile`

## Requirements
- R1: A frame is `0`,`1`, a two-bit opcode (`10` read, `01` write), a 5-bit PHY address, a 5-bit register address, two turnaround bits and 16 data bits, every field MSB first. Any run of leading ones, including none, is accepted.
- R2: During a read, `mdio_oe` rises after the management-clock rising edge that closes the first turnaround bit. The block drives `0` for the second turnaround bit, then data bits 15 down to 0, each changed after a rising edge. It releases the line after the edge that samples bit 0.
- R3: With `rpt_mode` low, a frame matches only when its address bits 4:2 are zero and bits 1:0 equal `phy_addr[1:0]`.
- R4: With `rpt_mode` high, a frame matches only when all five address bits equal `phy_addr`.
- R5: A frame that does not match, or has opcode `00` or `11`, changes no register and never raises `mdio_oe`.
- R6: Register 1 reads 0x7849. Bit 6 set means frames without a preamble are accepted.
- R7: Register 0 bits 13, 12, 11, 10 and 8 are writable, and the register resets to 0x3000. Bit 11 drives `pwr_down` and bit 10 drives `isolate`. All other register-0 bits read 0, except bit 15.
- R8: Writing 1 to register 0 bit 15 starts a soft reset. `soft_rst` is then high for exactly RST_CYCLES system clocks. Registers 0 and 4 return to their reset values and all counters clear. Bit 15 reads 1 only while the reset runs.
- R9: Registers 8 to 15 read 0, and writes to them have no effect.
- R10: Registers 20 to 25 count strobes on `evt[0]` to `evt[5]` respectively, one count per system clock the strobe is high. A value narrower than 16 bits reads zero-extended.
- R11: A counter that reaches all ones stays there under further strobes.
- R12: Reading a counter returns its value and clears it. A strobe in the clearing cycle leaves the counter at 1, so no event is lost.
- R13: Registers 2 and 3 read 0x0A5C and 0x5C31. Register 4 resets to 0x01E1 and is fully writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc | input | 1 | Management clock, sampled by clk |
| mdio_in | input | 1 | Management data seen on the line |
| phy_addr | input | 5 | Strapped PHY address |
| rpt_mode | input | 1 | 1 selects repeater address matching |
| evt | input | 6 | Event strobes for counters 20 to 25 |
| mdio_out | output | 1 | Management data driven during reads |
| mdio_oe | output | 1 | Drive enable for mdio_out |
| pwr_down | output | 1 | Power-down control |
| isolate | output | 1 | MII isolation control |
| soft_rst | output | 1 | High while a soft reset runs |

## Verification
A clear-on-read and a datapath increment can land on the same counter in the same clock. The bench holds one strobe high for a 100-cycle window that straddles the header end of a read frame sent with no preamble, so the clearing fetch falls inside the window. It then reads the counter again. The two read values must sum to exactly 100, which fails if the coincident event is dropped, double-counted, or lets the pre-clear value survive.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_HDR, S_READ, S_WRITE, S_SKIP
  } mstate_t;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  localparam int NUM_EVT = 6;

  localparam logic [4:0] REG_CTRL  = 5'd0;
  localparam logic [4:0] REG_STAT  = 5'd1;
  localparam logic [4:0] REG_ID_HI = 5'd2;
  localparam logic [4:0] REG_ID_LO = 5'd3;
  localparam logic [4:0] REG_ADV   = 5'd4;
  localparam int         REG_CNT0  = 20;
endpackage

// File: rtl/mgmt_frame.sv
module mgmt_frame
  import mgmt_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 16,
  parameter int ADAPT_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdc,
  input  logic              mdio_in,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic              rpt_mode,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              mdio_out,
  output logic              mdio_oe
);
  localparam int HDR_W = 2 + 2 * ADDR_W;
  localparam int TAIL  = DATA_W + 1;
  localparam int CW    = $clog2(TAIL + 1);

  logic              mdc_q, mdc_q2, mdio_q;
  mstate_t           st, st_n;
  logic [CW-1:0]     cnt, cnt_n;
  logic [HDR_W-1:0]  hdr, hdr_n, hdr_full;
  logic [DATA_W-1:0] sh, sh_n;
  logic [ADDR_W-1:0] ra_q, ra_n, pa_now, ra_now;
  logic [1:0]        op_now;
  logic              oe_n, out_n, rise, hit;

  assign rise     = mdc_q & ~mdc_q2;
  assign hdr_full = {hdr[HDR_W-2:0], mdio_q};
  assign op_now   = hdr_full[HDR_W-1 -: 2];
  assign pa_now   = hdr_full[2*ADDR_W-1 -: ADDR_W];
  assign ra_now   = hdr_full[ADDR_W-1:0];
  assign hit      = rpt_mode ? (pa_now == phy_addr)
                  : ((pa_now[ADDR_W-1:ADAPT_BITS] == '0) &&
                     (pa_now[ADAPT_BITS-1:0] == phy_addr[ADAPT_BITS-1:0]));
  assign reg_addr = (st == S_HDR) ? ra_now : ra_q;
  assign wr_data  = {sh[DATA_W-2:0], mdio_q};

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    hdr_n  = hdr;
    sh_n   = sh;
    ra_n   = ra_q;
    oe_n   = mdio_oe;
    out_n  = mdio_out;
    rd_stb = 1'b0;
    wr_stb = 1'b0;
    if (rise) begin
      case (st)
        S_IDLE:  if (!mdio_q) st_n = S_START;
        S_START: if (mdio_q) begin
          st_n  = S_HDR;
          cnt_n = '0;
        end
        S_HDR: begin
          hdr_n = hdr_full;
          cnt_n = cnt + 1'b1;
          if (cnt == CW'(HDR_W - 1)) begin
            cnt_n = '0;
            ra_n  = ra_now;
            if (op_now == OP_RD && hit) begin
              st_n   = S_READ;
              rd_stb = 1'b1;
              sh_n   = rd_data;
            end else if (op_now == OP_WR && hit) begin
              st_n = S_WRITE;
            end else begin
              st_n = S_SKIP;
            end
          end
        end
        S_READ: begin
          cnt_n = cnt + 1'b1;
          if (cnt == '0) begin
            oe_n  = 1'b1;
            out_n = 1'b0;
          end else if (cnt == CW'(TAIL)) begin
            oe_n  = 1'b0;
            out_n = 1'b0;
            st_n  = S_IDLE;
          end else begin
            out_n = sh[DATA_W-1];
            sh_n  = {sh[DATA_W-2:0], 1'b0};
          end
        end
        S_WRITE: begin
          cnt_n = cnt + 1'b1;
          sh_n  = {sh[DATA_W-2:0], mdio_q};
          if (cnt == CW'(TAIL)) begin
            wr_stb = 1'b1;
            st_n   = S_IDLE;
          end
        end
        S_SKIP: begin
          cnt_n = cnt + 1'b1;
          if (cnt == CW'(TAIL)) st_n = S_IDLE;
        end
        default: st_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_q    <= 1'b0;
      mdc_q2   <= 1'b0;
      mdio_q   <= 1'b1;
      st       <= S_IDLE;
      cnt      <= '0;
      hdr      <= '0;
      sh       <= '0;
      ra_q     <= '0;
      mdio_oe  <= 1'b0;
      mdio_out <= 1'b0;
    end else begin
      mdc_q    <= mdc;
      mdc_q2   <= mdc_q;
      mdio_q   <= mdio_in;
      st       <= st_n;
      cnt      <= cnt_n;
      hdr      <= hdr_n;
      sh       <= sh_n;
      ra_q     <= ra_n;
      mdio_oe  <= oe_n;
      mdio_out <= out_n;
    end
  end

  // R2: the line is only ever driven inside a read
  p_oe_in_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> (st == S_READ));
  // R2: the first driven bit is the low turnaround bit
  p_ta_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_out);
  // R2: released after the edge that samples bit 0
  p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && st == S_READ && cnt == CW'(TAIL)) |=> !mdio_oe);
  // R5: an ignored frame never drives the line
  p_quiet_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SKIP) |-> !mdio_oe);
endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             rd_clr,
  input  logic             evt,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_n;
  logic             full;

  assign full = &count;

  always_comb begin
    count_n = count;
    if (clr)               count_n = '0;
    else if (rd_clr)       count_n = CNT_W'(evt);
    else if (evt && !full) count_n = count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_n;
  end

  // R11: a saturated counter holds under further strobes
  p_sat_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr && !rd_clr) |=> (&count));
  // R12: after a clearing read at most the coincident event remains
  p_rd_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !clr) |=> (count <= CNT_W'(1)));
  // R8: soft reset wipes the counter
  p_wipe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
endmodule

// File: rtl/mgmt_regs.sv
module mgmt_regs
  import mgmt_pkg::*;
#(
  parameter int          CNT_W      = 16,
  parameter int          RST_CYCLES = 8,
  parameter logic [15:0] ID_HI      = 16'h0A5C,
  parameter logic [15:0] ID_LO      = 16'h5C31
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_stb,
  input  logic               wr_stb,
  input  logic [4:0]         reg_addr,
  input  logic [15:0]        wr_data,
  input  logic [NUM_EVT-1:0] evt,
  output logic [15:0]        rd_data,
  output logic               pwr_down,
  output logic               isolate,
  output logic               soft_rst
);
  localparam logic [15:0] CTRL_DEF  = 16'h3000;
  localparam logic [15:0] CTRL_MASK = 16'h3D00;
  localparam logic [15:0] ADV_DEF   = 16'h01E1;
  localparam logic [15:0] STAT_VAL  = 16'h7849;
  localparam int          RW        = $clog2(RST_CYCLES + 1);

  logic [15:0]        ctrl, ctrl_n, adv, adv_n;
  logic [RW-1:0]      rc, rc_n;
  logic [NUM_EVT-1:0] rd_clr;
  logic [CNT_W-1:0]   cnt_val [NUM_EVT];

  assign soft_rst = (rc != '0);
  assign pwr_down = ctrl[11];
  assign isolate  = ctrl[10];

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_cnt
    assign rd_clr[g] = rd_stb && (reg_addr == 5'(REG_CNT0 + g));
    evt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (soft_rst),
      .rd_clr (rd_clr[g]),
      .evt    (evt[g]),
      .count  (cnt_val[g])
    );
  end

  always_comb begin
    ctrl_n = ctrl;
    adv_n  = adv;
    rc_n   = soft_rst ? rc - 1'b1 : rc;
    if (wr_stb && !soft_rst) begin
      case (reg_addr)
        REG_CTRL: begin
          if (wr_data[15]) begin
            ctrl_n = CTRL_DEF;
            adv_n  = ADV_DEF;
            rc_n   = RW'(RST_CYCLES);
          end else begin
            ctrl_n = wr_data & CTRL_MASK;
          end
        end
        REG_ADV: adv_n = wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    case (reg_addr)
      REG_CTRL:  rd_data = {soft_rst, ctrl[14:0]};
      REG_STAT:  rd_data = STAT_VAL;
      REG_ID_HI: rd_data = ID_HI;
      REG_ID_LO: rd_data = ID_LO;
      REG_ADV:   rd_data = adv;
      default: begin
        for (int i = 0; i < NUM_EVT; i++)
          if (reg_addr == 5'(REG_CNT0 + i)) rd_data = 16'(cnt_val[i]);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= CTRL_DEF;
      adv  <= ADV_DEF;
      rc   <= '0;
    end else begin
      ctrl <= ctrl_n;
      adv  <= adv_n;
      rc   <= rc_n;
    end
  end

  // R8: control outputs sit at their reset values during a soft reset
  p_quiet_in_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (!pwr_down && !isolate));
  // R8: the soft reset runs its full length
  p_reset_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rc > RW'(1)) |=> soft_rst);
  // R7: control register holds only its writable bits
  p_ctrl_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl & ~CTRL_MASK) == '0);
endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
  import mgmt_pkg::*;
#(
  parameter int          CNT_W      = 16,
  parameter int          RST_CYCLES = 8,
  parameter logic [15:0] ID_HI      = 16'h0A5C,
  parameter logic [15:0] ID_LO      = 16'h5C31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mdc,
  input  logic         mdio_in,
  input  logic [4:0]   phy_addr,
  input  logic         rpt_mode,
  input  logic [5:0]   evt,
  output logic         mdio_out,
  output logic         mdio_oe,
  output logic         pwr_down,
  output logic         isolate,
  output logic         soft_rst
);
  logic        rst_s1, rst_s2;
  logic        rd_stb, wr_stb;
  logic [4:0]  reg_addr;
  logic [15:0] wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  mgmt_frame #(.ADDR_W(5), .DATA_W(16), .ADAPT_BITS(2)) u_frame (
    .clk      (clk),
    .rst_n    (rst_s2),
    .mdc      (mdc),
    .mdio_in  (mdio_in),
    .phy_addr (phy_addr),
    .rpt_mode (rpt_mode),
    .rd_data  (rd_data),
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb),
    .reg_addr (reg_addr),
    .wr_data  (wr_data),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe)
  );

  mgmt_regs #(
    .CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES), .ID_HI(ID_HI), .ID_LO(ID_LO)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_s2),
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb),
    .reg_addr (reg_addr),
    .wr_data  (wr_data),
    .evt      (evt),
    .rd_data  (rd_data),
    .pwr_down (pwr_down),
    .isolate  (isolate),
    .soft_rst (soft_rst)
  );
endmodule

// File: tb/phy_mgmt_regfile_tb.sv
module phy_mgmt_regfile_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mdc = 1'b0;
  logic       mdio_in = 1'b1;
  logic [4:0] phy_addr = 5'b00110;
  logic       rpt_mode = 1'b0;
  logic [5:0] evt = '0;
  logic       mdio_out, mdio_oe, pwr_down, isolate, soft_rst;

  int checks = 0;
  int errors = 0;
  int srst_len = 0;

  always #5 clk = ~clk;

  phy_mgmt_regfile #(.CNT_W(8), .RST_CYCLES(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_in(mdio_in),
    .phy_addr(phy_addr), .rpt_mode(rpt_mode), .evt(evt),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .pwr_down(pwr_down),
    .isolate(isolate), .soft_rst(soft_rst)
  );

  always @(posedge clk) if (soft_rst) srst_len <= srst_len + 1;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic mbit(input logic b, output logic so, output logic soe);
    @(negedge clk);
    mdc = 1'b0;
    mdio_in = b;
    repeat (4) @(negedge clk);
    so = mdio_out;
    soe = mdio_oe;
    mdc = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
                       input logic [15:0] wd, input bit pre,
                       output logic [15:0] rd, output bit tim_ok, output bit drove);
    logic so, soe;
    logic [13:0] hdr;
    hdr = {2'b01, op, pa, ra};
    rd = '0;
    tim_ok = 1'b1;
    drove = 1'b0;
    if (pre) for (int i = 0; i < 32; i++) begin
      mbit(1'b1, so, soe);
      drove |= soe;
    end
    for (int i = 13; i >= 0; i--) begin
      mbit(hdr[i], so, soe);
      drove |= soe;
    end
    for (int i = 0; i < 18; i++) begin
      logic b;
      if (op == 2'b10) b = 1'b1;
      else b = (i == 0) ? 1'b1 : (i == 1) ? 1'b0 : wd[17-i];
      mbit(b, so, soe);
      drove |= soe;
      if (i == 0) tim_ok &= !soe;
      else if (i == 1) tim_ok &= soe && !so;
      else begin
        rd[17-i] = so;
        tim_ok &= soe;
      end
    end
    mbit(1'b1, so, soe);
    drove |= soe;
    tim_ok &= !soe;
  endtask

  task automatic rd_reg(input logic [4:0] pa, input logic [4:0] ra, output logic [15:0] d,
                        output bit ok, output bit drove);
    frame(2'b10, pa, ra, 16'h0, 1'b1, d, ok, drove);
  endtask

  task automatic wr_reg(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
                        input logic [15:0] wd, output bit drove);
    logic [15:0] d;
    bit ok;
    frame(op, pa, ra, wd, 1'b1, d, ok, drove);
  endtask

  task automatic pulse(input int k, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) evt[k] = 1'b1;
      @(negedge clk) evt[k] = 1'b0;
    end
  endtask

  task automatic t_reset_state;
    chk("R7 reset pwr_down", {15'h0, pwr_down}, 16'h0);
    chk("R7 reset isolate", {15'h0, isolate}, 16'h0);
    chk("R2 reset oe", {15'h0, mdio_oe}, 16'h0);
    chk("R8 reset soft_rst", {15'h0, soft_rst}, 16'h0);
  endtask

  task automatic t_status_and_ids;
    logic [15:0] d; bit ok, dr;
    rd_reg(5'd2, 5'd1, d, ok, dr);
    chk("R6 status", d, 16'h7849);
    chk("R2 read timing", {15'h0, ok}, 16'h1);
    frame(2'b10, 5'd2, 5'd1, 16'h0, 1'b0, d, ok, dr);
    chk("R1 no preamble status", d, 16'h7849);
    chk("R1 no preamble timing", {15'h0, ok}, 16'h1);
    rd_reg(5'd2, 5'd2, d, ok, dr);
    chk("R13 id hi", d, 16'h0A5C);
    rd_reg(5'd2, 5'd3, d, ok, dr);
    chk("R13 id lo", d, 16'h5C31);
    rd_reg(5'd2, 5'd4, d, ok, dr);
    chk("R13 adv default", d, 16'h01E1);
  endtask

  task automatic t_write_ctrl;
    logic [15:0] d; bit ok, dr;
    wr_reg(2'b01, 5'd2, 5'd4, 16'hABCD, dr);
    rd_reg(5'd2, 5'd4, d, ok, dr);
    chk("R1 R13 adv write", d, 16'hABCD);
    wr_reg(2'b01, 5'd2, 5'd0, 16'h7FFF, dr);
    chk("R7 pwr_down set", {15'h0, pwr_down}, 16'h1);
    chk("R7 isolate set", {15'h0, isolate}, 16'h1);
    rd_reg(5'd2, 5'd0, d, ok, dr);
    chk("R7 ctrl mask", d, 16'h3D00);
  endtask

  task automatic t_addressing;
    logic [15:0] d; bit ok, dr;
    rd_reg(5'd6, 5'd1, d, ok, dr);
    chk("R3 adapter addr 6 ignored", {15'h0, dr}, 16'h0);
    rd_reg(5'd3, 5'd1, d, ok, dr);
    chk("R3 adapter addr 3 ignored", {15'h0, dr}, 16'h0);
    wr_reg(2'b01, 5'd6, 5'd4, 16'h1111, dr);
    wr_reg(2'b00, 5'd2, 5'd4, 16'h2222, dr);
    wr_reg(2'b11, 5'd2, 5'd4, 16'h3333, dr);
    chk("R5 no drive on bad opcode", {15'h0, dr}, 16'h0);
    rd_reg(5'd2, 5'd4, d, ok, dr);
    chk("R5 adv untouched", d, 16'hABCD);
    rpt_mode = 1'b1;
    rd_reg(5'd6, 5'd4, d, ok, dr);
    chk("R4 repeater addr 6", d, 16'hABCD);
    chk("R4 repeater timing", {15'h0, ok}, 16'h1);
    rd_reg(5'd2, 5'd4, d, ok, dr);
    chk("R4 repeater addr 2 ignored", {15'h0, dr}, 16'h0);
    rpt_mode = 1'b0;
  endtask

  task automatic t_reserved;
    logic [15:0] d; bit ok, dr;
    wr_reg(2'b01, 5'd2, 5'd9, 16'hFFFF, dr);
    rd_reg(5'd2, 5'd9, d, ok, dr);
    chk("R9 reg 9 zero", d, 16'h0);
    rd_reg(5'd2, 5'd8, d, ok, dr);
    chk("R9 reg 8 zero", d, 16'h0);
    rd_reg(5'd2, 5'd15, d, ok, dr);
    chk("R9 reg 15 zero", d, 16'h0);
  endtask

  task automatic t_counters;
    logic [15:0] d, d2; bit ok, dr;
    for (int k = 0; k < 6; k++) pulse(k, k + 3);
    for (int k = 0; k < 6; k++) begin
      rd_reg(5'd2, 5'(20 + k), d, ok, dr);
      chk($sformatf("R10 counter %0d", 20 + k), d, 16'(k + 3));
    end
    rd_reg(5'd2, 5'd21, d, ok, dr);
    chk("R12 cleared after read", d, 16'h0);
    pulse(0, 300);
    rd_reg(5'd2, 5'd20, d, ok, dr);
    chk("R11 saturate", d, 16'h00FF);
    fork
      frame(2'b10, 5'd2, 5'd22, 16'h0, 1'b0, d, ok, dr);
      begin
        repeat (60) @(negedge clk);
        evt[2] = 1'b1;
        repeat (100) @(negedge clk);
        evt[2] = 1'b0;
      end
    join
    rd_reg(5'd2, 5'd22, d2, ok, dr);
    chk("R12 coincident event kept", d + d2, 16'd100);
  endtask

  task automatic t_soft_reset;
    logic [15:0] d; bit ok, dr;
    pulse(4, 5);
    srst_len = 0;
    wr_reg(2'b01, 5'd2, 5'd0, 16'h8000, dr);
    chk("R8 soft reset length", 16'(srst_len), 16'd8);
    chk("R8 pwr_down cleared", {15'h0, pwr_down}, 16'h0);
    chk("R8 isolate cleared", {15'h0, isolate}, 16'h0);
    rd_reg(5'd2, 5'd0, d, ok, dr);
    chk("R8 ctrl default, bit15 clear", d, 16'h3000);
    rd_reg(5'd2, 5'd4, d, ok, dr);
    chk("R8 adv default", d, 16'h01E1);
    rd_reg(5'd2, 5'd24, d, ok, dr);
    chk("R8 counter cleared", d, 16'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset_state();
    t_status_and_ids();
    t_write_ctrl();
    t_addressing();
    t_reserved();
    t_counters();
    t_soft_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule